// File: doc/BRIEF.md
# Reconfigurable self-test register

A register of parameterised width for built-in self-test. A two-bit mode input selects its behaviour on each rising clock edge. It can clear itself. It can load a word in parallel, like an ordinary pipeline register. It can shift serially as part of a scan chain. It can also run a linear-feedback shift that XORs a parallel response word into its state on every clock. When that response word is held at zero, the same linear-feedback mode generates pseudo-random stimulus patterns for a circuit under test. When the word carries a circuit's output, the mode folds the whole response stream into one signature.

Two instances placed around a pair of logic blocks can exchange roles between test phases. One produces patterns while the other compacts the response, and then the other way round, because the mode can change on any cycle. At the end of a run, scan mode moves the signature out most-significant bit first, so that outside logic can compare it with a known-good value. The aliasing chance for a long response stream is about 2^-WIDTH, and this is the guide for choosing the width.

Top module: `bilbo_reg`

## Requirements
- R1: An active-low asynchronous reset clears the register to all zeros at once, without waiting for a clock edge.
- R2: With mode 2'b00 (clear), the register is all zeros after the next rising edge.
- R3: With mode 2'b11 (load), the register takes the value of par_in at the next rising edge.
- R4: With mode 2'b01 (scan), every bit moves one place toward the MSB, scan_in enters bit 0, and scan_out always shows bit WIDTH-1.
- R5: With mode 2'b10 and par_in at zero, the register steps as a maximal-length generator. The feedback bit is the XOR of the state bits selected by TAP_MASK and enters bit 0 as the state shifts toward the MSB. The default is WIDTH=4 with TAP_MASK=4'b1001, which is polynomial x^4+x^3+1. Starting from 4'b0001, the register visits 15 distinct nonzero states and is back at 4'b0001 after 15 steps.
- R6: With mode 2'b10, the next state is the shifted state with its feedback bit, XORed bitwise with par_in.
- R7: With mode 2'b10, if the register and par_in are both zero, the register loads the seed 0...01 instead, so it cannot lock up.
- R8: In mode 2'b10, all 2^WIDTH values, 0 included, can be reached as a signature by choosing par_in.
- R9: par_out always equals the register. A mode change takes effect at the very next rising edge, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 clear, 01 scan, 10 generate/compact, 11 load |
| par_in | input | WIDTH | Parallel load word or response word |
| scan_in | input | 1 | Serial input into bit 0 |
| par_out | output | WIDTH | Register contents, pattern output |
| scan_out | output | 1 | Serial output, bit WIDTH-1 |

## Verification
A wrong feedback tap or a missing XOR term shows on par_out one edge after the first compaction step. It changes every signature that follows. A shift error in scan mode shows on scan_out within WIDTH edges of an unload. A missing seed leaves par_out stuck at zero from the first generator edge onward. The reference model in the bench follows every edge, so any such difference is reported in the cycle it first appears.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;
  typedef enum logic [1:0] {
    BILBO_CLEAR   = 2'b00,
    BILBO_SCAN    = 2'b01,
    BILBO_COMPACT = 2'b10,
    BILBO_LOAD    = 2'b11
  } bilbo_mode_e;
endpackage

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] TAP_MASK = 4'b1001
) (
  input  logic [WIDTH-1:0] state,
  output logic             fb
);
  // XOR chain over the tapped bits, one stage per bit
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAP_MASK[i]) begin : g_on
      assign chain[i+1] = chain[i] ^ state[i];
    end else begin : g_off
      assign chain[i+1] = chain[i];
    end
  end
  assign fb = chain[WIDTH];
endmodule

// File: rtl/bilbo_next.sv
module bilbo_next
  import bilbo_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  bilbo_mode_e      mode,
  input  logic [WIDTH-1:0] state,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  input  logic             fb,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] shifted;
  logic             lockup;

  assign shifted = {state[WIDTH-2:0], fb};
  assign lockup  = (state == '0) && (par_in == '0);

  always_comb begin
    unique case (mode)
      BILBO_CLEAR:   nxt = '0;
      BILBO_SCAN:    nxt = {state[WIDTH-2:0], scan_in};
      BILBO_COMPACT: nxt = lockup ? SEED : (shifted ^ par_in);
      BILBO_LOAD:    nxt = par_in;
      default:       nxt = '0;
    endcase
  end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
  import bilbo_pkg::*;
#(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] TAP_MASK = 4'b1001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] par_in,
  input  logic             scan_in,
  output logic [WIDTH-1:0] par_out,
  output logic             scan_out
);
  bilbo_mode_e      mode_e;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;
  logic             fb;
  logic             state_en;

  assign mode_e   = bilbo_mode_e'(mode);
  assign state_en = 1'b1;

  bilbo_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) fb_i (
    .state (state_q),
    .fb    (fb)
  );

  bilbo_next #(.WIDTH(WIDTH)) next_i (
    .mode    (mode_e),
    .state   (state_q),
    .par_in  (par_in),
    .scan_in (scan_in),
    .fb      (fb),
    .nxt     (state_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  assign par_out  = state_q;
  assign scan_out = state_q[WIDTH-1];
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
  parameter int unsigned WIDTH = 4,
  parameter logic [WIDTH-1:0] TAP_MASK = 4'b1001
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] par_in,
  input logic             scan_in,
  input logic [WIDTH-1:0] par_out,
  input logic             scan_out
);
  localparam logic [WIDTH-1:0] SEED = {{(WIDTH-1){1'b0}}, 1'b1};

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b00 |=> par_out == '0);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b11 |=> par_out == $past(par_in));

  assert_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> (par_out[0] == $past(scan_in)) &&
                      (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0])));

  assert_scan_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'b01 |=> scan_out == $past(par_out[WIDTH-2]));

  assert_compact_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) && ((par_out != '0) || (par_in != '0)) |=>
    par_out == ({$past(par_out[WIDTH-2:0]), ^($past(par_out) & TAP_MASK)} ^ $past(par_in)));

  assert_seed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) && (par_out == '0) && (par_in == '0) |=> par_out == SEED);

  assert_gen_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) && (par_in == '0) |=> par_out != '0);
endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .par_in   (par_in),
  .scan_in  (scan_in),
  .par_out  (par_out),
  .scan_out (scan_out)
);

// File: tb/bilbo_reg_tb.sv
module bilbo_reg_tb_top;
  localparam int unsigned W = 4;
  localparam logic [W-1:0] MASK = 4'b1001;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   mode;
  logic [W-1:0] par_in;
  logic         scan_in;
  logic [W-1:0] par_out;
  logic         scan_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  bilbo_reg #(.WIDTH(W), .TAP_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .par_in(par_in),
    .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
  );

  function automatic logic [W-1:0] step(input logic [W-1:0] q, input logic [1:0] m,
                                        input logic [W-1:0] d, input logic s);
    logic [W-1:0] sh;
    sh = {q[W-2:0], ^(q & MASK)};
    case (m)
      2'b00: return '0;
      2'b01: return {q[W-2:0], s};
      2'b10: return ((q == '0) && (d == '0)) ? W'(1) : (sh ^ d);
      default: return d;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive after a falling edge, one rising edge, compare at next falling edge
  task automatic cycle(input string req, input logic [1:0] m, input logic [W-1:0] d, input logic s);
    mode = m; par_in = d; scan_in = s;
    model = step(model, m, d, s);
    @(posedge clk);
    @(negedge clk);
    check(req, par_out, model);
    check({req, "/R4 scan_out"}, W'(scan_out), W'(model[W-1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] seen;
    logic [W-1:0] first;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mode = 2'b11; par_in = 4'hA; scan_in = 1'b0;
    model = '0;
    repeat (2) @(negedge clk);
    check("R1 reset state", par_out, '0);
    rst_n = 1'b1;

    cycle("R3 load", 2'b11, 4'hB, 1'b0);
    cycle("R2 clear", 2'b00, 4'h7, 1'b1);
    cycle("R7 seed from zero", 2'b10, 4'h0, 1'b0);
    check("R7 seed value", par_out, 4'h1);

    // R5: generator period from 0001
    seen = '0;
    first = par_out;
    for (int i = 1; i <= 15; i++) begin
      cycle("R5 generator step", 2'b10, 4'h0, 1'b0);
      if (i < 15) begin
        checks++;
        if (seen[par_out] || par_out == first || par_out == '0) begin
          errors++;
          $display("FAIL R5 repeat at step %0d actual=%h expected=new", i, par_out);
        end
        seen[par_out] = 1'b1;
      end
    end
    check("R5 period 15 returns to 0001", par_out, 4'h1);

    // R8: every signature value reachable, zero included
    for (int v = 0; v < 16; v++) begin
      cycle("R8 preload", 2'b11, 4'h1, 1'b0);
      cycle("R8 reach", 2'b10, 4'h3 ^ W'(v), 1'b0);
      check("R8 target", par_out, W'(v));
    end

    // R4: scan unload, MSB first, with fill bits 1,0,1,1
    cycle("R3 load before unload", 2'b11, 4'hC, 1'b0);
    for (int i = 0; i < W; i++) begin
      logic bitexp;
      bitexp = (4'hC >> (W-1-i)) & 1'b1;
      check("R4 unload bit", W'(scan_out), W'(bitexp));
      cycle("R4 shift", 2'b01, 4'h0, (4'hB >> (W-1-i)) & 1'b1);
    end
    check("R4 scanned-in word", par_out, 4'hB);

    // R9 / R6: random mode switching every cycle
    for (int i = 0; i < 3000; i++) begin
      cycle("R9/R6 random", 2'($urandom), W'($urandom), 1'($urandom));
      check("R9 par_out mirrors", par_out, model);
    end

    // R1: asynchronous reset mid-cycle
    cycle("R3 load before reset", 2'b11, 4'hF, 1'b0);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1 async clear", par_out, '0);
    model = '0;
    @(negedge clk);
    rst_n = 1'b1;
    cycle("R6 compact after reset", 2'b10, 4'h6, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule